// File: doc/BRIEF.md
# Fully Associative Victim Buffer

This block is a small store that holds the blocks a first-level cache has just thrown out. It sits on the path between that cache and the next memory level. Its entries belong to no particular cache set, so it adds a few extra ways that every set shares. Each block comes in only when the cache evicts it. It leaves only when a later cache miss finds it here and it moves back into the cache.

The cache raises `lookupValid` with the block address only when its own tag check misses. All entries compare that address at once. The result appears in the same cycle as a one-hot `matchVec`, a `hitOut` flag and the stored block on `hitData`. On a hit the entry is freed at the next clock edge. If the cache also evicts a block in that cycle, the evicted block goes into the freed entry, so the two blocks trade places. On a miss the block address goes out on the next-level request port. Evicted blocks fill the lowest-numbered free entry. When no entry is free, the entry written longest ago is overwritten.

The cache must not evict a block that is already held here. The block address is the full address with the byte offset removed.

Top module: `vb_victim_buffer`

## Requirements
- R1: After reset every entry is empty, so every lookup misses until a block has been inserted.
- R2: A lookup whose address equals a held entry's address sets `hitOut` in the same cycle. It also sets the single bit of `matchVec` at that entry's index (bit i stands for entry i) and drives the entry's block on `hitData`.
- R3: `hitOut` is the OR of the `matchVec` bits. A valid lookup that misses raises `fetchReq` in the same cycle, with `fetchAddr` equal to `lookupAddr`. A hit never raises `fetchReq`.
- R4: With `lookupValid` low, `hitOut`, `matchVec` and `fetchReq` are all zero, `hitData` is zero, and no entry changes.
- R5: An eviction with no lookup hit in the same cycle, while some entry is free, writes the lowest-numbered free entry.
- R6: An eviction while all entries are full, with no lookup hit, overwrites the entry that was written earliest among the held ones.
- R7: An entry that hits is empty from the next cycle, so a repeated lookup of the same address misses unless it was inserted again.
- R8: An eviction in the same cycle as a lookup hit is written into the entry that hit.
- R9: Any block address can sit in any entry, so blocks whose low address bits are equal can be held at the same time.
- R10: `hitData` is zero whenever `hitOut` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evictValid | input | 1 | Cache is evicting a block this cycle |
| evictAddr | input | ADDR_W | Block address of the evicted block |
| evictData | input | DATA_W | Contents of the evicted block |
| lookupValid | input | 1 | Cache missed and asks for a search |
| lookupAddr | input | ADDR_W | Block address being searched |
| hitOut | output | 1 | Some entry matched the lookup |
| hitData | output | DATA_W | Block of the matching entry, zero otherwise |
| matchVec | output | ENTRIES | One-hot per-entry match result |
| fetchReq | output | 1 | Lookup missed, fetch from next level |
| fetchAddr | output | ADDR_W | Block address for the next-level fetch |

## Verification
The bench attacks the places where the choice of entry can go wrong. It checks that a freed hole is refilled before anything is overwritten; a design that overwrote the oldest entry regardless would lose a held block. It checks that overwriting follows true insertion age after holes have appeared; a plain rotating pointer would evict a young block. For an eviction in the same cycle as a hit, it checks that the evicted block lands in the entry that hit. If it landed elsewhere, a live block would be destroyed, and the next lookup would show the new block at the wrong `matchVec` bit. Lookups with `lookupValid` low carry an address that is held, and the same address is then searched. A design that searched anyway would flag a hit, or free the entry.

// File: rtl/vb_pkg.sv
package vb_pkg;
  // Width of the slot index carried in the strobe bundle; bounds ENTRIES to 256.
  localparam int SLOT_W = 8;

  typedef struct packed {
    logic              wrEn;    // write the evicted block this cycle
    logic [SLOT_W-1:0] wrSlot;  // entry index receiving it
  } vbStrobe_t;
endpackage

// File: rtl/vb_datapath.sv
module vb_datapath
  import vb_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 28,
  parameter int DATA_W  = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  vbStrobe_t            strobe,
  input  logic [ADDR_W-1:0]    evictAddr,
  input  logic [DATA_W-1:0]    evictData,
  input  logic [ADDR_W-1:0]    lookupAddr,
  input  logic [ENTRIES-1:0]   matchVec,
  output logic [ENTRIES-1:0]   tagEq,
  output logic [DATA_W-1:0]    hitData
);
  logic [ADDR_W-1:0] addrQ [ENTRIES];
  logic [DATA_W-1:0] dataQ [ENTRIES];

  // One storage slot plus one comparator per entry: the parallel search.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        addrQ[g] <= '0;
        dataQ[g] <= '0;
      end else if (strobe.wrEn && strobe.wrSlot == SLOT_W'(g)) begin
        addrQ[g] <= evictAddr;
        dataQ[g] <= evictData;
      end
    end
    assign tagEq[g] = (addrQ[g] == lookupAddr);
  end

  // AND-OR selection driven by the qualified one-hot vector.
  always_comb begin
    hitData = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (matchVec[i]) hitData = hitData | dataQ[i];
    end
  end
endmodule

// File: rtl/vb_control.sv
module vb_control
  import vb_pkg::*;
#(
  parameter int ENTRIES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lookupValid,
  input  logic               evictValid,
  input  logic [ENTRIES-1:0] tagEq,
  output logic [ENTRIES-1:0] matchVec,
  output logic               hitOut,
  output logic               fetchReq,
  output vbStrobe_t          strobe
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] validQ;
  logic [ENTRIES-1:0] oldestVec;
  // olderQ[i][j] set: entry i was written before entry j.
  logic [ENTRIES-1:0] olderQ [ENTRIES];
  logic [IDX_W-1:0]   hitIdx, freeIdx, oldIdx, wrIdx;
  logic               anyFree;

  assign matchVec = lookupValid ? (tagEq & validQ) : '0;
  assign hitOut   = |matchVec;
  assign fetchReq = lookupValid & ~hitOut;

  // An entry is oldest when it is held and older than every other held entry.
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      oldestVec[i] = validQ[i];
      for (int j = 0; j < ENTRIES; j++) begin
        if (j != i && validQ[j] && !olderQ[i][j]) oldestVec[i] = 1'b0;
      end
    end
  end

  // Priority encoders; the descending scan leaves the lowest index selected.
  always_comb begin
    hitIdx  = '0;
    freeIdx = '0;
    oldIdx  = '0;
    anyFree = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i])  hitIdx = IDX_W'(i);
      if (!validQ[i]) begin
        freeIdx = IDX_W'(i);
        anyFree = 1'b1;
      end
      if (oldestVec[i]) oldIdx = IDX_W'(i);
    end
    if (hitOut)       wrIdx = hitIdx;
    else if (anyFree) wrIdx = freeIdx;
    else              wrIdx = oldIdx;
  end

  assign strobe.wrEn   = evictValid;
  assign strobe.wrSlot = SLOT_W'(wrIdx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      validQ <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (evictValid && wrIdx == IDX_W'(i)) validQ[i] <= 1'b1;
        else if (matchVec[i])                 validQ[i] <= 1'b0;
      end
    end
  end

  // Writing entry k makes k younger than every other entry.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) olderQ[i] <= '0;
    end else if (evictValid) begin
      for (int i = 0; i < ENTRIES; i++) begin
        for (int j = 0; j < ENTRIES; j++) begin
          if (IDX_W'(j) == wrIdx && i != j) olderQ[i][j] <= 1'b1;
          else if (IDX_W'(i) == wrIdx)      olderQ[i][j] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/vb_victim_buffer.sv
module vb_victim_buffer
  import vb_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 28,
  parameter int DATA_W  = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               evictValid,
  input  logic [ADDR_W-1:0]  evictAddr,
  input  logic [DATA_W-1:0]  evictData,
  input  logic               lookupValid,
  input  logic [ADDR_W-1:0]  lookupAddr,
  output logic               hitOut,
  output logic [DATA_W-1:0]  hitData,
  output logic [ENTRIES-1:0] matchVec,
  output logic               fetchReq,
  output logic [ADDR_W-1:0]  fetchAddr
);
  vbStrobe_t          strobe;
  logic [ENTRIES-1:0] tagEq;

  vb_control #(.ENTRIES(ENTRIES)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .lookupValid(lookupValid), .evictValid(evictValid),
    .tagEq(tagEq), .matchVec(matchVec),
    .hitOut(hitOut), .fetchReq(fetchReq), .strobe(strobe)
  );

  vb_datapath #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .evictAddr(evictAddr), .evictData(evictData),
    .lookupAddr(lookupAddr), .matchVec(matchVec),
    .tagEq(tagEq), .hitData(hitData)
  );

  assign fetchAddr = lookupAddr;
endmodule

// File: rtl/vb_victim_buffer_chk.sv
module vb_victim_buffer_chk #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 28,
  parameter int DATA_W  = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               evictValid,
  input logic [ADDR_W-1:0]  evictAddr,
  input logic               lookupValid,
  input logic [ADDR_W-1:0]  lookupAddr,
  input logic               hitOut,
  input logic [ENTRIES-1:0] matchVec,
  input logic               fetchReq,
  input logic [ADDR_W-1:0]  fetchAddr
);
  // R2: never more than one entry answers a lookup
  p_onehot_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(matchVec));

  // R3: a hit suppresses the next-level request
  p_hit_no_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hitOut |-> !fetchReq);

  // R3: a request carries the searched block address
  p_fetch_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fetchReq |-> (lookupValid && fetchAddr == lookupAddr));

  // R4: idle lookup port produces nothing
  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !lookupValid |-> (matchVec == '0 && !hitOut && !fetchReq));

  // R7: a hit without a refill frees the entry
  p_hit_frees_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hitOut && !evictValid) |=> !(hitOut && lookupAddr == $past(lookupAddr)));

  // R8: a block evicted during a hit lands in the entry that hit
  p_swap_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hitOut && evictValid) ##1 (lookupValid && lookupAddr == $past(evictAddr))
      |-> matchVec == $past(matchVec));
endmodule

bind vb_victim_buffer vb_victim_buffer_chk #(
  .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) chk_i (
  .clk(clk), .rst_n(rst_n),
  .evictValid(evictValid), .evictAddr(evictAddr),
  .lookupValid(lookupValid), .lookupAddr(lookupAddr),
  .hitOut(hitOut), .matchVec(matchVec),
  .fetchReq(fetchReq), .fetchAddr(fetchAddr)
);

// File: tb/vb_victim_buffer_tb.sv
`timescale 1ns/1ps
module vb_victim_buffer_tb_top;
  localparam int NE = 4;
  localparam int AW = 28;
  localparam int DW = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          evictValid = 1'b0;
  logic [AW-1:0] evictAddr = '0;
  logic [DW-1:0] evictData = '0;
  logic          lookupValid = 1'b0;
  logic [AW-1:0] lookupAddr = '0;
  logic          hitOut;
  logic [DW-1:0] hitData;
  logic [NE-1:0] matchVec;
  logic          fetchReq;
  logic [AW-1:0] fetchAddr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  bit            mValid [NE];
  logic [AW-1:0] mAddr  [NE];
  logic [DW-1:0] mData  [NE];
  int            order  [$];

  always #2.5 clk = ~clk;

  vb_victim_buffer #(.ENTRIES(NE), .ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .evictValid(evictValid), .evictAddr(evictAddr), .evictData(evictData),
    .lookupValid(lookupValid), .lookupAddr(lookupAddr),
    .hitOut(hitOut), .hitData(hitData), .matchVec(matchVec),
    .fetchReq(fetchReq), .fetchAddr(fetchAddr)
  );

  task automatic chk(input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int modelHit(input logic lv, input logic [AW-1:0] la);
    int s = -1;
    if (lv) for (int i = 0; i < NE; i++) if (mValid[i] && mAddr[i] == la) s = i;
    return s;
  endfunction

  // One cycle: drive, compare combinational outputs, then advance the model.
  task automatic step(input logic ev, input logic [AW-1:0] ea, input logic [DW-1:0] ed,
                      input logic lv, input logic [AW-1:0] la, input string tag);
    int hs;
    int slot;
    logic [NE-1:0] expMatch;
    logic [DW-1:0] expData;
    @(negedge clk);
    evictValid = ev; evictAddr = ea; evictData = ed;
    lookupValid = lv; lookupAddr = la;
    #1;
    hs = modelHit(lv, la);
    expMatch = '0;
    expData  = '0;
    if (hs >= 0) begin
      expMatch[hs] = 1'b1;
      expData = mData[hs];
    end
    chk(tag, "hitOut", DW'(hitOut), DW'(hs >= 0));
    chk(tag, "matchVec", DW'(matchVec), DW'(expMatch));
    chk(tag, "hitData", hitData, expData);   // R10 zero on miss
    chk(tag, "fetchReq", DW'(fetchReq), DW'(lv && hs < 0));
    if (lv && hs < 0) chk(tag, "fetchAddr", DW'(fetchAddr), DW'(la));
    @(posedge clk);
    if (hs >= 0) begin
      mValid[hs] = 0;
      for (int k = 0; k < order.size(); k++)
        if (order[k] == hs) begin order.delete(k); break; end
    end
    if (ev) begin
      slot = hs;
      if (slot < 0)
        for (int i = NE - 1; i >= 0; i--) if (!mValid[i]) slot = i;
      if (slot < 0) begin
        slot = order[0];
        order.delete(0);
      end
      mValid[slot] = 1; mAddr[slot] = ea; mData[slot] = ed;
      order.push_back(slot);
    end
  endtask

  function automatic logic [DW-1:0] blk(input logic [AW-1:0] a);
    return {a[27:0], 4'h5, ~a[27:0], 4'hA};
  endfunction

  // pool of block addresses with identical low bits (R9)
  function automatic logic [AW-1:0] poolAddr(input int k);
    return AW'((k * 32'h0013_1000) + 32'h0000_0010);
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] a [6];
    for (int i = 0; i < NE; i++) mValid[i] = 0;
    for (int i = 0; i < 6; i++) a[i] = poolAddr(i + 1);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: empty after reset, lookup misses and goes to next level (R3)
    step(0, '0, '0, 1, a[0], "R1 R3");
    step(0, '0, '0, 1, a[3], "R1");
    // R5: fills go to slots 0..3 in order, idle lookup port (R4)
    for (int i = 0; i < 4; i++) step(1, a[i], blk(a[i]), 0, '0, "R5 R4 R9");
    // R4: held address presented with lookupValid low: no effect
    step(0, '0, '0, 0, a[2], "R4");
    // R2: hit on entry 2, low bits shared by all (R9)
    step(0, '0, '0, 1, a[2], "R2 R9");
    // R7: entry freed by the hit
    step(0, '0, '0, 1, a[2], "R7");
    // R5: the hole at slot 2 is refilled first
    step(1, a[4], blk(a[4]), 0, '0, "R5");
    step(0, '0, '0, 1, a[4], "R5 R2");
    // R6: full buffer, overwrite earliest written (slot 0, a[0])
    step(1, a[4], blk(a[4]), 0, '0, "R6");
    step(1, a[2], blk(a[2]), 0, '0, "R6");
    step(0, '0, '0, 1, a[0], "R6");
    step(0, '0, '0, 1, a[1], "R6 R2");
    // R8: evict during a hit on a[3]; new block takes that entry
    step(1, a[5], blk(a[5]), 1, a[3], "R8");
    step(0, '0, '0, 1, a[5], "R8");
    step(0, '0, '0, 1, a[3], "R8 R7");

    // mixed traffic, exclusivity kept: never evict a held block except the one hitting
    for (int n = 0; n < 400; n++) begin
      logic lv, ev;
      logic [AW-1:0] la, ea;
      int hs;
      lv = ($urandom % 3) != 0;
      la = poolAddr($urandom % 10);
      hs = modelHit(lv, la);
      ev = 0; ea = '0;
      if (($urandom % 3) != 0) begin
        for (int t = 0; t < 8 && !ev; t++) begin
          ea = poolAddr($urandom % 10);
          ev = (modelHit(1'b1, ea) < 0) || (hs >= 0 && ea == la);
        end
        if (!ev) ea = '0;
      end
      step(ev, ea, blk(ea) ^ DW'(n), lv, la, "R2 R3 R5 R6 R8 R10");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule